// File: doc/BRIEF.md
# Address-Assignment Request Responder

This block sits beside the control-endpoint stage sequencer of a device-side bus controller. When a setup packet has been decoded and its five request fields stored, the sequencer pulses `req_valid` for one cycle. If the request assigns the device address and passes every field and state check, the block answers it without software. It raises `auto_busy`, which tells the sequencer to run the no-data status stage itself, meaning the host's zero-length IN transaction. It then waits for `status_ack`, which reports that this stage completed with an ACK.

Only after that acknowledgement does the new 7-bit address reach `dev_addr`. At the same moment the block issues a one-cycle `state_wr` pulse carrying the new device-state code on `state_new`. The tracker that owns the state code applies it and feeds it back on `dev_state`. Any other request, and any faulty address request, is passed to software with a one-cycle `sw_pass` pulse. A faulty address request also sets `req_err`, which stays high until the next request arrives. All pins are plain control and status lines, and there is no streaming interface with back-pressure.

Top module: `set_addr_responder`

## Requirements
- R1: After reset `dev_addr` is 0, `state_new` is 3'b001, and `auto_busy`, `req_err`, `sw_pass` and `state_wr` are all 0.
- R2: A request whose request byte is not 0x05 causes a one-cycle `sw_pass` pulse in the cycle after `req_valid`. It does not set `auto_busy` or `req_err` and does not change `dev_addr`.
- R3: An address request (request byte 0x05) whose type byte is not 0x00 sets `req_err` and pulses `sw_pass` one cycle after `req_valid`, and `auto_busy` stays 0.
- R4: An address request with a nonzero index field or a nonzero length field is handled as in R3.
- R5: An address request whose value field exceeds 0x7F is handled as in R3.
- R6: An address request is handled as in R3 when its value is nonzero while `dev_state` is 3'b011 (configured), or when its value is zero while `dev_state` is 3'b001 (default).
- R7: An address request that passes all checks sets `auto_busy` one cycle after `req_valid` and gives no `sw_pass` pulse. `dev_addr` keeps its old value until the status acknowledgement arrives.
- R8: `status_ack` while `auto_busy` is high loads `dev_addr` with the low 7 bits of the value field and pulses `state_wr` for one cycle, both one cycle later. In that cycle `state_new` is 3'b010 (address) if the value is nonzero and 3'b001 (default) if it is zero, and `auto_busy` clears.
- R9: `status_ack` while nothing is pending changes neither `dev_addr` nor `state_wr`.
- R10: A new request while one is pending replaces it. A later acknowledgement commits only the newest request, or nothing if that request was not an accepted address request.
- R11: `req_err` is cleared by the next `req_valid` that is not itself a faulty address request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle pulse: new request fields are stored |
| req_type | input | 8 | Request type byte |
| req_code | input | 8 | Request byte |
| req_value | input | 16 | Value field |
| req_index | input | 16 | Index field |
| req_length | input | 16 | Length field |
| dev_state | input | 3 | Current device-state code |
| status_ack | input | 1 | Status stage completed with an ACK |
| dev_addr | output | 7 | Device address in use |
| state_new | output | 3 | New device-state code, valid with state_wr |
| state_wr | output | 1 | One-cycle pulse: apply state_new |
| auto_busy | output | 1 | Accepted address request is awaiting its status stage |
| req_err | output | 1 | Last address request failed a check |
| sw_pass | output | 1 | One-cycle pulse: request handed to software |

## Verification
The verdict on a request, meaning `auto_busy`, `req_err` and `sw_pass`, is registered once and is due one cycle after `req_valid`. The commit, meaning `dev_addr`, `state_new` and `state_wr`, is due one cycle after `status_ack`. The bench changes inputs on falling edges and holds each pulse for exactly one clock. It samples on the next falling edge, which falls half a period after the single register stage updates. `state_wr` is then sampled again one period later to confirm that it was a single pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned FIELD_W = 16;

  typedef enum logic [STATE_W-1:0] {
    ST_DEFAULT    = 3'b001,
    ST_ADDRESSED  = 3'b010,
    ST_CONFIGURED = 3'b011
  } dev_state_e;

  localparam logic [7:0] CODE_SET_ADDR = 8'h05;
  localparam logic [7:0] TYPE_STD_DEV  = 8'h00;
endpackage

// File: rtl/sar_req_check.sv
module sar_req_check
  import sar_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned SW = STATE_W
) (
  input  logic [7:0]    req_type,
  input  logic [7:0]    req_code,
  input  logic [FW-1:0] req_value,
  input  logic [FW-1:0] req_index,
  input  logic [FW-1:0] req_length,
  input  logic [SW-1:0] dev_state,
  output logic          is_set_addr,
  output logic          fields_ok
);
  localparam logic [FW-1:0] VAL_MAX = FW'((1 << AW) - 1);

  logic bad_type, bad_index, bad_length, bad_range, bad_cfg, bad_dflt, val_nz;

  always_comb begin
    is_set_addr = (req_code == CODE_SET_ADDR);
    val_nz      = |req_value;
    bad_type    = (req_type != TYPE_STD_DEV);
    bad_index   = |req_index;
    bad_length  = |req_length;
    bad_range   = (req_value > VAL_MAX);
    bad_cfg     = val_nz && (dev_state == SW'(ST_CONFIGURED));
    bad_dflt    = !val_nz && (dev_state == SW'(ST_DEFAULT));
    fields_ok   = !(bad_type || bad_index || bad_length || bad_range || bad_cfg || bad_dflt);
  end
endmodule

// File: rtl/sar_commit.sv
module sar_commit
  import sar_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned SW = STATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          is_set_addr,
  input  logic          fields_ok,
  input  logic [AW-1:0] new_addr,
  input  logic          status_ack,
  output logic [AW-1:0] dev_addr,
  output logic [SW-1:0] state_new,
  output logic          state_wr,
  output logic          auto_busy,
  output logic          req_err,
  output logic          sw_pass
);
  logic [AW-1:0] shadow_q;
  logic          accept;

  assign accept = is_set_addr && fields_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_addr  <= '0;
      shadow_q  <= '0;
      state_new <= SW'(ST_DEFAULT);
      state_wr  <= 1'b0;
      auto_busy <= 1'b0;
      req_err   <= 1'b0;
      sw_pass   <= 1'b0;
    end else begin
      sw_pass  <= 1'b0;
      state_wr <= 1'b0;
      if (req_valid) begin
        // newest request always wins over one awaiting its status stage
        auto_busy <= accept;
        req_err   <= is_set_addr && !fields_ok;
        sw_pass   <= !accept;
        shadow_q  <= new_addr;
      end else if (auto_busy && status_ack) begin
        auto_busy <= 1'b0;
        dev_addr  <= shadow_q;
        state_wr  <= 1'b1;
        state_new <= (|shadow_q) ? SW'(ST_ADDRESSED) : SW'(ST_DEFAULT);
      end
    end
  end
endmodule

// File: rtl/set_addr_responder.sv
module set_addr_responder
  import sar_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned SW = STATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [7:0]    req_type,
  input  logic [7:0]    req_code,
  input  logic [FW-1:0] req_value,
  input  logic [FW-1:0] req_index,
  input  logic [FW-1:0] req_length,
  input  logic [SW-1:0] dev_state,
  input  logic          status_ack,
  output logic [AW-1:0] dev_addr,
  output logic [SW-1:0] state_new,
  output logic          state_wr,
  output logic          auto_busy,
  output logic          req_err,
  output logic          sw_pass
);
  logic is_set_addr, fields_ok;

  sar_req_check #(.AW(AW), .FW(FW), .SW(SW)) u_check (
    .req_type(req_type), .req_code(req_code), .req_value(req_value),
    .req_index(req_index), .req_length(req_length), .dev_state(dev_state),
    .is_set_addr(is_set_addr), .fields_ok(fields_ok)
  );

  sar_commit #(.AW(AW), .SW(SW)) u_commit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .is_set_addr(is_set_addr), .fields_ok(fields_ok),
    .new_addr(req_value[AW-1:0]), .status_ack(status_ack),
    .dev_addr(dev_addr), .state_new(state_new), .state_wr(state_wr),
    .auto_busy(auto_busy), .req_err(req_err), .sw_pass(sw_pass)
  );
endmodule

// File: rtl/sar_sva.sv
module sar_sva #(
  parameter int unsigned AW = 7,
  parameter int unsigned SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          status_ack,
  input logic [AW-1:0] dev_addr,
  input logic [SW-1:0] state_new,
  input logic          state_wr,
  input logic          auto_busy,
  input logic          req_err,
  input logic          sw_pass
);
  // R7: an accepted request never also reports an error
  p_busy_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(auto_busy && req_err));

  // R7: the address only moves on a commit
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !state_wr |-> $stable(dev_addr));

  // R8: a commit needs a pending request and an acknowledgement
  p_commit_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_wr |-> ($past(auto_busy) && $past(status_ack) && !$past(req_valid)));

  // R8: state code matches the committed address
  p_commit_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_wr |-> (state_new == ((dev_addr != '0) ? SW'(3'b010) : SW'(3'b001))));

  // R8: busy clears on commit
  p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_wr |-> !auto_busy);

  // R2: a handoff is always caused by a request
  p_pass_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pass |-> $past(req_valid));

  // R3: a new error always comes with a handoff
  p_err_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_err) |-> sw_pass);

  // R9: without a pending request an acknowledgement commits nothing
  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_busy && !req_valid) |=> !state_wr);
endmodule

bind set_addr_responder sar_sva #(.AW(AW), .SW(SW)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .status_ack(status_ack),
  .dev_addr(dev_addr), .state_new(state_new), .state_wr(state_wr),
  .auto_busy(auto_busy), .req_err(req_err), .sw_pass(sw_pass)
);

// File: tb/set_addr_responder_test.sv
module set_addr_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_type = '0, req_code = '0;
  logic [15:0] req_value = '0, req_index = '0, req_length = '0;
  logic [2:0]  dev_state = 3'b001;
  logic        status_ack = 1'b0;
  logic [6:0]  dev_addr;
  logic [2:0]  state_new;
  logic        state_wr, auto_busy, req_err, sw_pass;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  set_addr_responder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_code(req_code), .req_value(req_value), .req_index(req_index),
    .req_length(req_length), .dev_state(dev_state), .status_ack(status_ack),
    .dev_addr(dev_addr), .state_new(state_new), .state_wr(state_wr),
    .auto_busy(auto_busy), .req_err(req_err), .sw_pass(sw_pass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] t, input logic [7:0] c, input logic [15:0] v,
                      input logic [15:0] i, input logic [15:0] l);
    @(negedge clk);
    req_type = t; req_code = c; req_value = v; req_index = i; req_length = l;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack_and_check(input string tag, input logic exp_wr,
                               input logic [6:0] exp_addr, input logic [2:0] exp_state);
    status_ack = 1'b1;
    @(negedge clk);
    status_ack = 1'b0;
    chk({tag, " state_wr"}, 32'(state_wr), 32'(exp_wr));
    chk({tag, " dev_addr"}, 32'(dev_addr), 32'(exp_addr));
    if (exp_wr) begin
      chk({tag, " state_new"}, 32'(state_new), 32'(exp_state));
      chk({tag, " busy cleared"}, 32'(auto_busy), 32'd0);
      dev_state = state_new;
    end
    @(negedge clk);
    chk({tag, " state_wr single"}, 32'(state_wr), 32'd0);
  endtask

  task automatic expect_err(input string tag);
    chk({tag, " req_err"}, 32'(req_err), 32'd1);
    chk({tag, " sw_pass"}, 32'(sw_pass), 32'd1);
    chk({tag, " auto_busy"}, 32'(auto_busy), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 dev_addr", 32'(dev_addr), 32'd0);
    chk("R1 state_new", 32'(state_new), 32'd1);
    chk("R1 flags", {28'd0, state_wr, auto_busy, req_err, sw_pass}, 32'd0);
  endtask

  task automatic t_other;
    send(8'h80, 8'h06, 16'h0100, 16'h0, 16'h12);
    chk("R2 sw_pass", 32'(sw_pass), 32'd1);
    chk("R2 no err", 32'(req_err), 32'd0);
    chk("R2 no busy", 32'(auto_busy), 32'd0);
    @(negedge clk);
    chk("R2 pulse single", 32'(sw_pass), 32'd0);
    chk("R2 addr kept", 32'(dev_addr), 32'd0);
  endtask

  task automatic t_field_errors;
    send(8'h01, 8'h05, 16'h10, 16'h0, 16'h0);  expect_err("R3 type");
    send(8'h00, 8'h05, 16'h10, 16'h1, 16'h0);  expect_err("R4 index");
    send(8'h00, 8'h05, 16'h10, 16'h0, 16'h2);  expect_err("R4 length");
    send(8'h00, 8'h05, 16'h80, 16'h0, 16'h0);  expect_err("R5 value");
    send(8'h00, 8'h05, 16'h0, 16'h0, 16'h0);   expect_err("R6 zero in default");
    @(negedge clk);
    ack_and_check("R9 ack after error", 1'b0, 7'd0, 3'b001);
  endtask

  task automatic t_good_flow;
    send(8'h00, 8'h05, 16'h2A, 16'h0, 16'h0);
    chk("R7 busy", 32'(auto_busy), 32'd1);
    chk("R7 no pass", 32'(sw_pass), 32'd0);
    chk("R11 err cleared", 32'(req_err), 32'd0);
    @(negedge clk); @(negedge clk);
    chk("R7 addr held", 32'(dev_addr), 32'd0);
    ack_and_check("R8 commit", 1'b1, 7'h2A, 3'b010);
  endtask

  task automatic t_idle_ack;
    ack_and_check("R9 idle ack", 1'b0, 7'h2A, 3'b010);
  endtask

  task automatic t_replace;
    send(8'h00, 8'h05, 16'h11, 16'h0, 16'h0);
    send(8'h00, 8'h05, 16'h33, 16'h0, 16'h0);
    chk("R10 still busy", 32'(auto_busy), 32'd1);
    ack_and_check("R10 newest", 1'b1, 7'h33, 3'b010);
    send(8'h00, 8'h05, 16'h44, 16'h0, 16'h0);
    send(8'h80, 8'h00, 16'h0, 16'h0, 16'h2);
    chk("R10 dropped", 32'(auto_busy), 32'd0);
    ack_and_check("R10 no commit", 1'b0, 7'h33, 3'b010);
  endtask

  task automatic t_to_default;
    send(8'h00, 8'h05, 16'h0, 16'h0, 16'h0);
    chk("R6 zero in address ok", 32'(auto_busy), 32'd1);
    ack_and_check("R8 back to default", 1'b1, 7'd0, 3'b001);
  endtask

  task automatic t_configured;
    dev_state = 3'b011;
    send(8'h00, 8'h05, 16'h05, 16'h0, 16'h0);
    expect_err("R6 nonzero in configured");
    send(8'h00, 8'h05, 16'h0, 16'h0, 16'h0);
    chk("R11 err cleared", 32'(req_err), 32'd0);
    chk("R6 zero in configured ok", 32'(auto_busy), 32'd1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_other();
    t_field_errors();
    t_good_flow();
    t_idle_ack();
    t_replace();
    t_to_default();
    t_configured();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule